// File: doc/BRIEF.md
# I2C Master START Condition Generator

This block is the front end of an I2C master. It creates the START condition on an open-drain bus and includes the countdown timer that paces each bus phase. The timer takes its reload value from the low seven bits of an eight-bit configuration input. After a load it counts down to zero and then stops there. It leaves zero only when the sequencer requests a new load.

To request a START, software pulses `start_set`. The request is accepted only if both synchronised bus lines read high. The block then waits one full baud period and checks the lines again. If both are still high, it pulls SDA low while leaving SCL released, which is the START condition, and sets `start_seen`. It then waits a second full period, clears `start_en` by itself and keeps SDA low for the byte logic that follows. If either line is found low at one of the two checks, the attempt ends. In that case `bus_coll` is set and both lines are released.

During the second phase the timer follows clock arbitration. While a device holds SCL low, the count is suspended. The timer reloads only once SCL is seen high again.

Top module: `i2c_start_gen`

States and transitions of the sequencer:

- `SEQ_IDLE`
  - *accept*: a request arrives with both lines high; go to `SEQ_SETUP`.
  - *reject*: a request arrives with either line low; stay in `SEQ_IDLE` and set the collision flag.
- `SEQ_SETUP`
  - *fall*: the period expires with both lines high; drive SDA low and go to `SEQ_HOLDOFF`.
  - *abort*: the period expires with either line low; return to `SEQ_IDLE` and set the collision flag.
- `SEQ_HOLDOFF`
  - *finish*: the period expires; go to `SEQ_DONE`.
- `SEQ_DONE`
  - Stays here until reset, with SDA held low.

## Requirements
- R1: After a synchronous reset, all of the following are 0: `sda_drive_low`, `scl_drive_low`, `start_en`, `start_seen` and `bus_coll`.
- R2: A `start_set` pulse seen in idle while both synchronised lines are high makes `start_en` read 1 one clock later. On that same edge `start_seen` and `bus_coll` are cleared.
- R3: A `start_set` pulse seen in idle while either synchronised line is low leaves `start_en` at 0 and sets `bus_coll` one clock later. Both line drives stay at 0.
- R4: After acceptance, `sda_drive_low` rises exactly (reload+1) clocks after the accepting edge. The reload is `reload_cfg[6:0]`, and bit 7 has no effect on timing.
- R5: `start_seen` becomes 1 on the same edge on which `sda_drive_low` rises.
- R6: `start_en` clears exactly (reload+1) clocks after SDA falls. `sda_drive_low` then stays 1 until reset, and `scl_drive_low` is never 1.
- R7: If either line reads low at the end of the first period, all of the following happen on that edge: `bus_coll` is set, `start_en` is cleared, SDA is released and `start_seen` stays 0.
- R8: A reload value of 0 gives a one-clock period in each phase.
- R9: If SCL reads low during the second phase, the count is suspended. It reloads on the first clock on which SCL reads high again, and `start_en` clears (reload+1) clocks after that reload.
- R10: A `start_set` pulse arriving after acceptance and before reset has no effect. The timing, `start_seen`, `bus_coll` and the line drives are all unchanged.
- R11: Both `sda_in` and `scl_in` pass through a two-flop synchroniser. A line that returns high only one clock before a request is still seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reload_cfg | input | 8 | Baud reload value; only bits 6:0 are used |
| start_set | input | 1 | One-clock request to begin a START |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| scl_drive_low | output | 1 | 1 pulls SCL low (open-drain enable) |
| start_en | output | 1 | Start-enable bit; hardware clears it |
| start_seen | output | 1 | START condition has been driven |
| bus_coll | output | 1 | A request or sequence saw a busy bus |

## Verification
The assertions check several relationships on every cycle:
- SCL is never driven.
- SDA, once pulled low, stays low.
- `start_seen` rises together with the SDA fall.
- A raised collision flag always comes with released lines.
- An accepting edge always clears both flags.

The exact period lengths depend on the reload value. These are shown only by the bench scenarios:
- the (reload+1) timing, including bit 7 being ignored and the zero reload;
- the delay added by SCL stretching;
- the two-clock synchroniser latency on a request;
- the absence of any effect from extra requests.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_SETUP   = 2'd1,
        SEQ_HOLDOFF = 2'd2,
        SEQ_DONE    = 2'd3
    } seq_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES    = 2,
    parameter bit IDLE_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic line_raw,
    output logic line_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= IDLE_LVL;
                    else     chain_q[0] <= line_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= IDLE_LVL;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign line_sync = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_baud_counter.sv
module i2c_baud_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_req,
    input  logic             arb_en,
    input  logic             scl_high,
    input  logic [CNT_W-1:0] reload_val,
    output logic             timeout
);
    logic [CNT_W-1:0] cnt_q;
    logic             wait_scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            wait_scl_q <= 1'b0;
        end else if (load_req) begin
            cnt_q      <= reload_val;
            wait_scl_q <= 1'b0;
        end else if (arb_en && !scl_high) begin
            wait_scl_q <= 1'b1;
        end else if (wait_scl_q && scl_high) begin
            cnt_q      <= reload_val;
            wait_scl_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign timeout = (cnt_q == '0) && !wait_scl_q;
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
    import i2c_start_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_set,
    input  logic sda_high,
    input  logic scl_high,
    input  logic timeout,
    output logic load_req,
    output logic arb_en,
    output logic sda_drv,
    output logic scl_drv,
    output logic start_en,
    output logic start_seen,
    output logic bus_coll
);
    seq_state_t state_q, state_d;
    logic       lines_free;
    logic       ev_accept, ev_reject, ev_fall, ev_abort, ev_finish;

    assign lines_free = sda_high && scl_high;

    always_comb begin
        ev_accept = 1'b0;
        ev_reject = 1'b0;
        ev_fall   = 1'b0;
        ev_abort  = 1'b0;
        ev_finish = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_set) begin
                    if (lines_free) begin
                        ev_accept = 1'b1;
                        state_d   = SEQ_SETUP;
                    end else begin
                        ev_reject = 1'b1;
                    end
                end
            end
            SEQ_SETUP: begin
                if (timeout) begin
                    if (lines_free) begin
                        ev_fall = 1'b1;
                        state_d = SEQ_HOLDOFF;
                    end else begin
                        ev_abort = 1'b1;
                        state_d  = SEQ_IDLE;
                    end
                end
            end
            SEQ_HOLDOFF: begin
                if (timeout) begin
                    ev_finish = 1'b1;
                    state_d   = SEQ_DONE;
                end
            end
            SEQ_DONE: state_d = SEQ_DONE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_drv    <= 1'b0;
            start_en   <= 1'b0;
            start_seen <= 1'b0;
            bus_coll   <= 1'b0;
        end else begin
            if (ev_accept) begin
                start_en   <= 1'b1;
                start_seen <= 1'b0;
                bus_coll   <= 1'b0;
            end
            if (ev_reject) begin
                bus_coll <= 1'b1;
                start_en <= 1'b0;
            end
            if (ev_fall) begin
                sda_drv    <= 1'b1;
                start_seen <= 1'b1;
            end
            if (ev_abort) begin
                bus_coll <= 1'b1;
                start_en <= 1'b0;
                sda_drv  <= 1'b0;
            end
            if (ev_finish) begin
                start_en <= 1'b0;
            end
        end
    end

    assign load_req = ev_accept || ev_fall;
    assign arb_en   = (state_q == SEQ_HOLDOFF);
    assign scl_drv  = 1'b0;
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
    parameter int CFG_W       = 8,
    parameter int RELOAD_W    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] reload_cfg,
    input  logic             start_set,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sda_drive_low,
    output logic             scl_drive_low,
    output logic             start_en,
    output logic             start_seen,
    output logic             bus_coll
);
    localparam int USED_W = (RELOAD_W < CFG_W) ? RELOAD_W : CFG_W;

    logic                sda_s, scl_s;
    logic                load_req, arb_en, timeout;
    logic [USED_W-1:0]   reload_val;

    assign reload_val = reload_cfg[USED_W-1:0];

    i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync_sda (
        .clk(clk), .rst(rst), .line_raw(sda_in), .line_sync(sda_s)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync_scl (
        .clk(clk), .rst(rst), .line_raw(scl_in), .line_sync(scl_s)
    );

    i2c_baud_counter #(.CNT_W(USED_W)) u_baud (
        .clk(clk), .rst(rst), .load_req(load_req), .arb_en(arb_en),
        .scl_high(scl_s), .reload_val(reload_val), .timeout(timeout)
    );

    i2c_start_seq u_seq (
        .clk(clk), .rst(rst), .start_set(start_set),
        .sda_high(sda_s), .scl_high(scl_s), .timeout(timeout),
        .load_req(load_req), .arb_en(arb_en),
        .sda_drv(sda_drive_low), .scl_drv(scl_drive_low),
        .start_en(start_en), .start_seen(start_seen), .bus_coll(bus_coll)
    );
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
    input logic clk,
    input logic rst,
    input logic sda_drive_low,
    input logic scl_drive_low,
    input logic start_en,
    input logic start_seen,
    input logic bus_coll
);
    AST_SCL_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !scl_drive_low); // R6

    AST_SDA_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        sda_drive_low |=> sda_drive_low); // R6

    AST_SEEN_WITH_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> (start_seen && start_en)); // R5

    AST_COLL_RELEASED: assert property (@(posedge clk) disable iff (rst)
        bus_coll |-> (!sda_drive_low && !start_seen)); // R7

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(start_en) |-> (!bus_coll && !start_seen && !sda_drive_low)); // R2

    AST_EN_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(start_en) |-> ((sda_drive_low && start_seen) || bus_coll)); // R6
endmodule

bind i2c_start_gen i2c_start_gen_chk u_chk (
    .clk(clk), .rst(rst), .sda_drive_low(sda_drive_low),
    .scl_drive_low(scl_drive_low), .start_en(start_en),
    .start_seen(start_seen), .bus_coll(bus_coll)
);

// File: tb/tb_i2c_start_gen.sv
module tb_i2c_start_gen;
    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reload_cfg = 8'd0;
    logic       start_set = 1'b0;
    logic       ext_sda_low = 1'b0;
    logic       ext_scl_low = 1'b0;
    logic       sda_in, scl_in;
    logic       sda_drive_low, scl_drive_low, start_en, start_seen, bus_coll;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign sda_in = ~(sda_drive_low | ext_sda_low);
    assign scl_in = ~(scl_drive_low | ext_scl_low);

    i2c_start_gen dut (
        .clk(clk), .rst(rst), .reload_cfg(reload_cfg), .start_set(start_set),
        .sda_in(sda_in), .scl_in(scl_in), .sda_drive_low(sda_drive_low),
        .scl_drive_low(scl_drive_low), .start_en(start_en),
        .start_seen(start_seen), .bus_coll(bus_coll)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] cfg);
        @(negedge clk);
        rst = 1'b1; ext_sda_low = 1'b0; ext_scl_low = 1'b0;
        start_set = 1'b0; reload_cfg = cfg;
        wait_n(3);
        rst = 1'b0;
        wait_n(4);
    endtask

    // returns at the negedge just after the edge that sampled the request
    task automatic pulse_start();
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
    endtask

    // full sequence with reload n; checks first and second period lengths
    task automatic run_full(input string req, input int n);
        pulse_start();
        chk(req, "en after accept", start_en, 1'b1);
        chk(req, "coll after accept", bus_coll, 1'b0);
        wait_n(n);
        chk(req, "sda before first timeout", sda_drive_low, 1'b0);
        wait_n(1);
        chk(req, "sda at first timeout", sda_drive_low, 1'b1);
        chk("R5", "seen with sda fall", start_seen, 1'b1);
        wait_n(n);
        chk(req, "en before second timeout", start_en, 1'b1);
        wait_n(1);
        chk(req, "en at second timeout", start_en, 1'b0);
        chk("R6", "sda held after done", sda_drive_low, 1'b1);
        wait_n(5);
        chk("R6", "sda still held", sda_drive_low, 1'b1);
        chk("R6", "scl never driven", scl_drive_low, 1'b0);
    endtask

    task automatic t_reset();
        do_reset(8'd4);
        chk("R1", "sda", sda_drive_low, 1'b0);
        chk("R1", "scl", scl_drive_low, 1'b0);
        chk("R1", "en", start_en, 1'b0);
        chk("R1", "seen", start_seen, 1'b0);
        chk("R1", "coll", bus_coll, 1'b0);
    endtask

    task automatic t_nominal();
        do_reset(8'd5);
        run_full("R4", 5);
    endtask

    task automatic t_bit7();
        do_reset(8'h83);
        run_full("R4", 3);
    endtask

    task automatic t_zero();
        do_reset(8'h00);
        run_full("R8", 0);
    endtask

    task automatic t_reject(input bit use_scl);
        do_reset(8'd4);
        if (use_scl) ext_scl_low = 1'b1; else ext_sda_low = 1'b1;
        wait_n(4);
        pulse_start();
        chk("R3", "en stays low", start_en, 1'b0);
        chk("R3", "coll set", bus_coll, 1'b1);
        chk("R3", "sda released", sda_drive_low, 1'b0);
        ext_sda_low = 1'b0; ext_scl_low = 1'b0;
        wait_n(4);
        pulse_start();
        chk("R2", "accept after reject", start_en, 1'b1);
        chk("R2", "coll cleared", bus_coll, 1'b0);
    endtask

    task automatic t_sync();
        do_reset(8'd4);
        ext_sda_low = 1'b1;
        wait_n(4);
        ext_sda_low = 1'b0;
        wait_n(1);
        pulse_start();
        chk("R11", "late release still low", bus_coll, 1'b1);
        chk("R11", "en stays low", start_en, 1'b0);
    endtask

    task automatic t_abort();
        do_reset(8'd10);
        pulse_start();
        wait_n(2);
        ext_sda_low = 1'b1;
        wait_n(10 + 1 - 2 - 1);
        chk("R7", "en before timeout", start_en, 1'b1);
        wait_n(1);
        chk("R7", "coll at timeout", bus_coll, 1'b1);
        chk("R7", "en cleared", start_en, 1'b0);
        chk("R7", "sda released", sda_drive_low, 1'b0);
        chk("R7", "seen stays low", start_seen, 1'b0);
    endtask

    task automatic t_ignore();
        do_reset(8'd6);
        pulse_start();
        wait_n(1);
        pulse_start();   // consumes one negedge, total 2 after accept
        wait_n(6 - 2);
        chk("R10", "sda before timeout", sda_drive_low, 1'b0);
        wait_n(1);
        chk("R10", "sda falls on time", sda_drive_low, 1'b1);
        wait_n(6 + 1 + 2);
        pulse_start();
        chk("R10", "en after late request", start_en, 1'b0);
        chk("R10", "seen kept", start_seen, 1'b1);
        chk("R10", "coll unchanged", bus_coll, 1'b0);
        chk("R10", "sda still held", sda_drive_low, 1'b1);
    endtask

    task automatic t_arb();
        do_reset(8'd10);
        pulse_start();
        wait_n(11);
        chk("R9", "sda fell", sda_drive_low, 1'b1);
        ext_scl_low = 1'b1;
        wait_n(8);
        ext_scl_low = 1'b0;
        wait_n(10 + 3);
        chk("R9", "en held by stretch", start_en, 1'b1);
        wait_n(1);
        chk("R9", "en clears after reload", start_en, 1'b0);
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_bit7();
        t_zero();
        t_reject(1'b0);
        t_reject(1'b1);
        t_sync();
        t_abort();
        t_ignore();
        t_arb();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule